// File: doc/BRIEF.md
# Privileged Status and Exception-Return Control Unit

This unit holds the privileged machine state of a simple in-order processor core: a status word, the two exception-return addresses (one for ordinary exceptions, one for error-level exceptions) and a count register that advances each time software reads it. Software reaches these through one register port: a register number plus 32-bit write data, and a read strobe whose data comes back in the same cycle.

The unit also carries out three privileged operations, each started by a one-cycle strobe: interrupt enable, interrupt disable and exception return. Interrupt enable and disable change the interrupt-enable bit only when the core is privileged, or when a dedicated override bit in the status word is set. Exception return selects its return address from the error-level flag and clears that flag, or else the exception-level flag. It then requests a PC redirect on the following cycle.

A combinational condition output compares two 10-bit DMA channel vectors. The condition holds when every channel is either flagged as interrupting or excluded by its mask. Coprocessor-conditional branches use this condition. In their plain form they redirect only when taken. In their "likely" form a branch that is not taken redirects past its delay slot.

Top module: `sysctl_unit`

## Requirements
- R1: After reset, a read of the status register (number 12) returns 0x00000004 (only the error-level flag set), the two return-address registers read 0, kernel_mode is 1 and redirect_valid is 0.
- R2: A status write stores all 32 bits. A status read returns the stored word ANDed with 0xF0C79C1F.
- R3: kernel_mode is 1 when status bit 1 (exception level) or bit 2 (error level) is set, or when the 2-bit privilege field in bits 4:3 is zero.
- R4: Interrupt enable sets and interrupt disable clears status bit 16. Either one acts only when kernel_mode is 1 or status bit 17 (enable/disable override) is set. Otherwise it leaves the status word unchanged.
- R5: Exception return with the error-level flag set drives redirect_valid high one cycle later, with redirect_pc equal to the error return register (number 30), and clears the error-level flag.
- R6: Exception return with the error-level flag clear redirects to the exception return register (number 14) and clears the exception-level flag.
- R7: When exception return and a status write occur in the same cycle, the written value is stored except for the flag that the return clears, which ends up 0.
- R8: cond_true is 1 exactly when the bitwise OR of dma_cis and the inverse of dma_chan_mask is all ones across the 10 channels.
- R9: A conditional branch (bc_en) is taken when cond_true equals bc_on_true. A taken branch redirects to bc_target on the next cycle. A plain branch that is not taken produces no redirect.
- R10: A likely branch (bc_likely=1) that is not taken redirects to pc_in + 4, skipping the delay slot at pc_in.
- R11: Each read of the count register (number 9) advances it by the number of cycles since the previous count read or write. The advance is at least 1, and the read returns the advanced value.
- R12: A write to the count register loads the written value and restarts the elapsed-cycle reference from that cycle.
- R13: The return-address registers read back what was written. A register number outside 9, 12, 14 and 30 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd_en | input | 1 | Register read strobe; data on reg_rdata in the same cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number for read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (0 when no read) |
| op_ei | input | 1 | Interrupt-enable operation strobe |
| op_di | input | 1 | Interrupt-disable operation strobe |
| op_eret | input | 1 | Exception-return operation strobe |
| bc_en | input | 1 | Conditional branch strobe |
| bc_on_true | input | 1 | 1 = branch when condition true, 0 = when false |
| bc_likely | input | 1 | 1 = likely form (skip delay slot when not taken) |
| pc_in | input | 32 | Address of the branch delay slot |
| bc_target | input | 32 | Branch target address |
| dma_cis | input | 10 | Per-channel interrupt-status flags |
| dma_chan_mask | input | 10 | Per-channel mask (1 = channel considered) |
| cond_true | output | 1 | Branch condition |
| kernel_mode | output | 1 | Privileged mode indicator |
| redirect_valid | output | 1 | PC redirect request, one cycle after the operation |
| redirect_pc | output | 32 | Redirect address |

## Verification
The hardest case to reach is the minimum-of-one advance of the count register. It arises only when the cycle counter still equals the last reference, and that happens only on the first cycle after reset leaves the counter and the reference both at zero. The bench applies a fresh reset and reads the count register in the very cycle reset falls. It then spaces later reads and a write by known idle gaps, so every expected value follows from cycle arithmetic alone. The collision of exception return with a status write is driven in a single cycle and judged by a later masked read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int CTL_W = 32;

    // register numbers decoded by the instruction decoder
    typedef enum logic [4:0] {
        REG_COUNT  = 5'd9,
        REG_STATUS = 5'd12,
        REG_EPC    = 5'd14,
        REG_ERRPC  = 5'd30
    } ctl_reg_e;

    // status word field positions
    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_KSU_L = 3;
    localparam int ST_KSU_H = 4;
    localparam int ST_EIE   = 16;
    localparam int ST_EDI   = 17;

    localparam logic [CTL_W-1:0] STATUS_RD_MASK  = 32'hF0C7_9C1F;
    localparam logic [CTL_W-1:0] STATUS_RST_VAL  = 32'h0000_0004;
    localparam logic [CTL_W-1:0] DELAY_SLOT_STEP = 32'd4;

    typedef struct packed {
        logic ei;
        logic di;
        logic eret;
    } priv_op_t;

    typedef struct packed {
        logic en;
        logic on_true;
        logic likely;
    } branch_req_t;

    function automatic logic is_kernel(input logic [CTL_W-1:0] st);
        return st[ST_EXL] | st[ST_ERL] | (st[ST_KSU_H:ST_KSU_L] == 2'b00);
    endfunction

    function automatic logic [CTL_W-1:0] elapsed_step(input logic [CTL_W-1:0] now_cyc,
                                                      input logic [CTL_W-1:0] ref_cyc);
        logic [CTL_W-1:0] d;
        d = now_cyc - ref_cyc;
        return (d == '0) ? {{(CTL_W-1){1'b0}}, 1'b1} : d;
    endfunction

endpackage

// File: rtl/sysctl_status.sv
module sysctl_status
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [4:0]       wr_addr,
    input  logic [CTL_W-1:0] wr_data,
    input  priv_op_t         op,
    output logic [CTL_W-1:0] status_q,
    output logic [CTL_W-1:0] epc_q,
    output logic [CTL_W-1:0] errpc_q,
    output logic             kernel
);

    logic             wr_status;
    logic             wr_epc;
    logic             wr_errpc;
    logic             ie_allowed;
    logic [CTL_W-1:0] status_d;

    assign wr_status = wr_en && (wr_addr == REG_STATUS);
    assign wr_epc    = wr_en && (wr_addr == REG_EPC);
    assign wr_errpc  = wr_en && (wr_addr == REG_ERRPC);

    assign kernel     = is_kernel(status_q);
    assign ie_allowed = kernel | status_q[ST_EDI];

    always_comb begin
        status_d = wr_status ? wr_data : status_q;
        if (op.eret) begin
            // the flag being retired is chosen from the state before this cycle
            if (status_q[ST_ERL]) begin
                status_d[ST_ERL] = 1'b0;
            end else begin
                status_d[ST_EXL] = 1'b0;
            end
        end else if ((op.ei || op.di) && ie_allowed) begin
            status_d[ST_EIE] = op.ei;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RST_VAL;
            epc_q    <= '0;
            errpc_q  <= '0;
        end else begin
            status_q <= status_d;
            if (wr_epc) begin
                epc_q <= wr_data;
            end
            if (wr_errpc) begin
                errpc_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sysctl_count.sv
module sysctl_count
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_value
);

    logic [CTL_W-1:0] cyc_q;
    logic [CTL_W-1:0] ref_q;
    logic [CTL_W-1:0] count_q;

    assign rd_value = count_q + elapsed_step(cyc_q, ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= '0;
            ref_q   <= '0;
            count_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (wr_hit) begin
                count_q <= wr_data;
                ref_q   <= cyc_q;
            end else if (rd_hit) begin
                count_q <= rd_value;
                ref_q   <= cyc_q;
            end
        end
    end

endmodule

// File: rtl/sysctl_cond.sv
module sysctl_cond #(
    parameter int NCHAN = 10
) (
    input  logic [NCHAN-1:0] cis,
    input  logic [NCHAN-1:0] chan_mask,
    output logic             cond
);

    logic [NCHAN-1:0] chan_ok;

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        assign chan_ok[g] = cis[g] | ~chan_mask[g];
    end

    assign cond = &chan_ok;

endmodule

// File: rtl/sysctl_redirect.sv
module sysctl_redirect
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eret,
    input  logic             erl,
    input  logic [CTL_W-1:0] epc,
    input  logic [CTL_W-1:0] errpc,
    input  branch_req_t      br,
    input  logic             cond,
    input  logic [CTL_W-1:0] pc_in,
    input  logic [CTL_W-1:0] target,
    output logic             valid_q,
    output logic [CTL_W-1:0] pc_q
);

    logic taken;
    assign taken = br.en && (cond == br.on_true);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pc_q    <= '0;
        end else if (eret) begin
            valid_q <= 1'b1;
            pc_q    <= erl ? errpc : epc;
        end else if (taken) begin
            valid_q <= 1'b1;
            pc_q    <= target;
        end else if (br.en && br.likely) begin
            valid_q <= 1'b1;
            pc_q    <= pc_in + DELAY_SLOT_STEP;
        end else begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
    import sysctl_pkg::*;
#(
    parameter int NCHAN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_rd_en,
    input  logic             reg_wr_en,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             op_ei,
    input  logic             op_di,
    input  logic             op_eret,
    input  logic             bc_en,
    input  logic             bc_on_true,
    input  logic             bc_likely,
    input  logic [31:0]      pc_in,
    input  logic [31:0]      bc_target,
    input  logic [NCHAN-1:0] dma_cis,
    input  logic [NCHAN-1:0] dma_chan_mask,
    output logic             cond_true,
    output logic             kernel_mode,
    output logic             redirect_valid,
    output logic [31:0]      redirect_pc
);

    priv_op_t         op;
    branch_req_t      br;
    logic [CTL_W-1:0] status_q;
    logic [CTL_W-1:0] epc_q;
    logic [CTL_W-1:0] errpc_q;
    logic [CTL_W-1:0] count_rd;
    logic             count_rd_hit;
    logic             count_wr_hit;

    assign op = '{ei: op_ei, di: op_di, eret: op_eret};
    assign br = '{en: bc_en, on_true: bc_on_true, likely: bc_likely};

    assign count_rd_hit = reg_rd_en && (reg_addr == REG_COUNT);
    assign count_wr_hit = reg_wr_en && (reg_addr == REG_COUNT);

    sysctl_status i_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .op       (op),
        .status_q (status_q),
        .epc_q    (epc_q),
        .errpc_q  (errpc_q),
        .kernel   (kernel_mode)
    );

    sysctl_count i_count (
        .clk      (clk),
        .rst      (rst),
        .rd_hit   (count_rd_hit),
        .wr_hit   (count_wr_hit),
        .wr_data  (reg_wdata),
        .rd_value (count_rd)
    );

    sysctl_cond #(.NCHAN(NCHAN)) i_cond (
        .cis       (dma_cis),
        .chan_mask (dma_chan_mask),
        .cond      (cond_true)
    );

    sysctl_redirect i_redirect (
        .clk     (clk),
        .rst     (rst),
        .eret    (op_eret),
        .erl     (status_q[ST_ERL]),
        .epc     (epc_q),
        .errpc   (errpc_q),
        .br      (br),
        .cond    (cond_true),
        .pc_in   (pc_in),
        .target  (bc_target),
        .valid_q (redirect_valid),
        .pc_q    (redirect_pc)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            case (reg_addr)
                REG_STATUS: reg_rdata = status_q & STATUS_RD_MASK;
                REG_COUNT:  reg_rdata = count_rd;
                REG_EPC:    reg_rdata = epc_q;
                REG_ERRPC:  reg_rdata = errpc_q;
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_rd_en,
    input logic        reg_wr_en,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        op_ei,
    input logic        op_di,
    input logic        op_eret,
    input logic        bc_en,
    input logic        bc_on_true,
    input logic        bc_likely,
    input logic        cond_true,
    input logic        kernel_mode,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic [31:0] status_q,
    input logic [31:0] errpc_q
);

    a_r2_read_masked: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == REG_STATUS) |-> ((reg_rdata & ~STATUS_RD_MASK) == '0));

    a_r4_ie_blocked: assert property (@(posedge clk) disable iff (rst)
        ((op_ei || op_di) && !kernel_mode && !status_q[ST_EDI] && !op_eret
         && !(reg_wr_en && reg_addr == REG_STATUS)) |=> $stable(status_q));

    a_r5_eret_erl_clear: assert property (@(posedge clk) disable iff (rst)
        (op_eret && status_q[ST_ERL]) |=> !status_q[ST_ERL]);

    a_r5_eret_errpc: assert property (@(posedge clk) disable iff (rst)
        (op_eret && status_q[ST_ERL]) |=> (redirect_valid && redirect_pc == $past(errpc_q)));

    a_r6_eret_exl_clear: assert property (@(posedge clk) disable iff (rst)
        (op_eret && !status_q[ST_ERL]) |=> !status_q[ST_EXL]);

    a_r9_plain_not_taken: assert property (@(posedge clk) disable iff (rst)
        (bc_en && !bc_likely && (cond_true != bc_on_true) && !op_eret) |=> !redirect_valid);

    a_r9_idle_no_redirect: assert property (@(posedge clk) disable iff (rst)
        (!bc_en && !op_eret) |=> !redirect_valid);

endmodule

bind sysctl_unit sysctl_checker i_sysctl_checker (
    .clk            (clk),
    .rst            (rst),
    .reg_rd_en      (reg_rd_en),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_rdata      (reg_rdata),
    .op_ei          (op_ei),
    .op_di          (op_di),
    .op_eret        (op_eret),
    .bc_en          (bc_en),
    .bc_on_true     (bc_on_true),
    .bc_likely      (bc_likely),
    .cond_true      (cond_true),
    .kernel_mode    (kernel_mode),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .status_q       (status_q),
    .errpc_q        (errpc_q)
);

// File: tb/test_sysctl_unit.sv
`timescale 1ns/1ps
module test_sysctl_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_rd_en = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        op_ei = 1'b0;
    logic        op_di = 1'b0;
    logic        op_eret = 1'b0;
    logic        bc_en = 1'b0;
    logic        bc_on_true = 1'b0;
    logic        bc_likely = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] bc_target = '0;
    logic [9:0]  dma_cis = '0;
    logic [9:0]  dma_chan_mask = '0;
    logic        cond_true;
    logic        kernel_mode;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [4:0] A_COUNT  = 5'd9;
    localparam logic [4:0] A_STATUS = 5'd12;
    localparam logic [4:0] A_EPC    = 5'd14;
    localparam logic [4:0] A_ERRPC  = 5'd30;

    always #4 clk = ~clk;

    sysctl_unit i_sysctl_unit (
        .clk(clk), .rst(rst),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_ei(op_ei), .op_di(op_di), .op_eret(op_eret),
        .bc_en(bc_en), .bc_on_true(bc_on_true), .bc_likely(bc_likely),
        .pc_in(pc_in), .bc_target(bc_target),
        .dma_cis(dma_cis), .dma_chan_mask(dma_chan_mask),
        .cond_true(cond_true), .kernel_mode(kernel_mode),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic pulse_ei(input bit en);
        op_ei = en; op_di = !en;
        @(negedge clk);
        op_ei = 1'b0; op_di = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 kernel_mode", {31'd0, kernel_mode}, 32'd1);
        check("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
        rd(A_STATUS, v); check("R1 status", v, 32'h4);
        rd(A_EPC, v);    check("R1 epc", v, 32'h0);
        rd(A_ERRPC, v);  check("R1 errpc", v, 32'h0);
    endtask

    task automatic t_status_mask();
        logic [31:0] v;
        wr(A_STATUS, 32'hFFFF_FFFF);
        rd(A_STATUS, v); check("R2 all ones masked", v, 32'hF0C7_9C1F);
        wr(A_STATUS, 32'h0F38_63E0);
        rd(A_STATUS, v); check("R2 masked-out bits", v, 32'h0000_0000);
    endtask

    task automatic t_kernel();
        wr(A_STATUS, 32'h18); check("R3 user", {31'd0, kernel_mode}, 32'd0);
        wr(A_STATUS, 32'h08); check("R3 ksu=1", {31'd0, kernel_mode}, 32'd0);
        wr(A_STATUS, 32'h1A); check("R3 exl", {31'd0, kernel_mode}, 32'd1);
        wr(A_STATUS, 32'h1C); check("R3 erl", {31'd0, kernel_mode}, 32'd1);
        wr(A_STATUS, 32'h00); check("R3 ksu=0", {31'd0, kernel_mode}, 32'd1);
    endtask

    task automatic t_ei_di();
        logic [31:0] v;
        wr(A_STATUS, 32'h18); pulse_ei(1'b1);
        rd(A_STATUS, v); check("R4 ei blocked in user", v, 32'h18);
        wr(A_STATUS, 32'h10018); pulse_ei(1'b0);
        rd(A_STATUS, v); check("R4 di blocked in user", v, 32'h10018);
        wr(A_STATUS, 32'h20018); pulse_ei(1'b1);
        rd(A_STATUS, v); check("R4 ei via override", v, 32'h30018);
        pulse_ei(1'b0);
        rd(A_STATUS, v); check("R4 di via override", v, 32'h20018);
        wr(A_STATUS, 32'h0); pulse_ei(1'b1);
        rd(A_STATUS, v); check("R4 ei in kernel", v, 32'h10000);
    endtask

    task automatic t_eret();
        logic [31:0] v;
        wr(A_ERRPC, 32'h0000_1000);
        wr(A_EPC, 32'h0000_2000);
        wr(A_STATUS, 32'h6);
        op_eret = 1'b1; @(negedge clk); op_eret = 1'b0;
        check("R5 redirect valid", {31'd0, redirect_valid}, 32'd1);
        check("R5 redirect pc", redirect_pc, 32'h1000);
        rd(A_STATUS, v); check("R5 erl cleared", v, 32'h2);
        op_eret = 1'b1; @(negedge clk); op_eret = 1'b0;
        check("R6 redirect pc", redirect_pc, 32'h2000);
        check("R6 redirect valid", {31'd0, redirect_valid}, 32'd1);
        rd(A_STATUS, v); check("R6 exl cleared", v, 32'h0);
        check("R9 no redirect when idle", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_eret_collide();
        logic [31:0] v;
        wr(A_STATUS, 32'h4);
        op_eret = 1'b1; reg_wr_en = 1'b1; reg_addr = A_STATUS; reg_wdata = 32'h6;
        @(negedge clk);
        op_eret = 1'b0; reg_wr_en = 1'b0;
        check("R7 redirect to errpc", redirect_pc, 32'h1000);
        rd(A_STATUS, v); check("R7 erl forced clear", v, 32'h2);
    endtask

    task automatic t_cond();
        dma_cis = 10'h3FF; dma_chan_mask = 10'h3FF; #1;
        check("R8 all flagged", {31'd0, cond_true}, 32'd1);
        dma_cis = 10'h000; dma_chan_mask = 10'h001; #1;
        check("R8 one masked-in idle", {31'd0, cond_true}, 32'd0);
        dma_cis = 10'h000; dma_chan_mask = 10'h000; #1;
        check("R8 none considered", {31'd0, cond_true}, 32'd1);
        dma_cis = 10'h1FF; dma_chan_mask = 10'h3FF; #1;
        check("R8 top channel missing", {31'd0, cond_true}, 32'd0);
        dma_cis = 10'h155; dma_chan_mask = 10'h155; #1;
        check("R8 partial mask met", {31'd0, cond_true}, 32'd1);
        @(negedge clk);
    endtask

    task automatic branch(input bit c, input bit on_true, input bit likely);
        dma_cis = '0; dma_chan_mask = c ? 10'h000 : 10'h3FF;
        pc_in = 32'h100; bc_target = 32'h400;
        bc_en = 1'b1; bc_on_true = on_true; bc_likely = likely;
        @(negedge clk);
        bc_en = 1'b0; bc_likely = 1'b0; bc_on_true = 1'b0;
    endtask

    task automatic t_branch();
        branch(1'b1, 1'b1, 1'b0);
        check("R9 taken on true valid", {31'd0, redirect_valid}, 32'd1);
        check("R9 taken on true pc", redirect_pc, 32'h400);
        branch(1'b0, 1'b0, 1'b0);
        check("R9 taken on false pc", redirect_pc, 32'h400);
        branch(1'b1, 1'b0, 1'b0);
        check("R9 plain not taken", {31'd0, redirect_valid}, 32'd0);
        branch(1'b1, 1'b0, 1'b1);
        check("R10 likely not taken valid", {31'd0, redirect_valid}, 32'd1);
        check("R10 likely not taken pc", redirect_pc, 32'h104);
        branch(1'b0, 1'b1, 1'b1);
        check("R10 likely on true not taken pc", redirect_pc, 32'h104);
        branch(1'b1, 1'b1, 1'b1);
        check("R10 likely taken pc", redirect_pc, 32'h400);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        rd(A_COUNT, v); check("R11 first read minimum step", v, 32'd1);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); check("R11 elapsed five", v, 32'd6);
        rd(A_COUNT, v); check("R11 back to back", v, 32'd7);
        wr(A_COUNT, 32'd100);
        repeat (2) @(negedge clk);
        rd(A_COUNT, v); check("R12 write restarts reference", v, 32'd103);
    endtask

    task automatic t_other();
        logic [31:0] v;
        wr(A_EPC, 32'hDEAD_BEEF);
        rd(A_EPC, v); check("R13 epc readback", v, 32'hDEAD_BEEF);
        wr(A_ERRPC, 32'h1234_5678);
        rd(A_ERRPC, v); check("R13 errpc readback", v, 32'h1234_5678);
        wr(5'd5, 32'hFFFF_FFFF);
        rd(5'd5, v); check("R13 unknown reads zero", v, 32'h0);
        rd(A_EPC, v); check("R13 unknown write no effect", v, 32'hDEAD_BEEF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_status_mask();
        t_kernel();
        t_ei_di();
        t_eret();
        t_eret_collide();
        t_cond();
        t_branch();
        t_other();
        t_count();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule